// File: doc/BRIEF.md
# Byte-Wide Passive Configuration Loader

This block is the host side of a byte-wide passive configuration link. It takes a bitstream from a byte source that uses a valid/ready handshake and sends it to a configuration target. When started, it drives the target's active-low configuration reset for a fixed number of cycles. It then waits until the target's status line reports ready. After that it presents each byte on an 8-bit bus and toggles a configuration clock whose half period is a parameter.

In compressed or secure mode each byte is held for four configuration clock periods, and the target takes it on the first rising edge. The target's done flag may rise one byte before the stream ends. The host keeps clocking until it has sent the byte flagged as last, and only then decides whether the load worked. After the load it waits for init-done to rise. When the user-supplied init clock option is selected, it drives that clock for at least a minimum number of periods. A ratio divider derived from the system clock and the allowed maximum frequency sets the rate of that clock. The host reports success when init-done has risen and any required init clocks have been sent. It reports a sticky failure when done never came or the init phase timed out.

Top module: `cfg_loader`

## Requirements
- R1: After reset, busy, ok, fail, src_ready, tgt_dclk and tgt_uclk are 0 and tgt_cfg_n is 1.
- R2: A start pulse while idle or after success drives tgt_cfg_n low for exactly RST_CYC system cycles. Afterwards, while tgt_status_n is 0, src_ready and tgt_dclk stay 0.
- R3: tgt_data does not change while tgt_dclk is high. Every high phase of tgt_dclk lasts exactly DCLK_HALF system cycles. Every low phase lasts at least DCLK_HALF system cycles.
- R4: With compress=0 each byte gets exactly one rising edge of tgt_dclk. With compress=1 each byte is held for four rising edges, and the byte is valid on the first of them. Bytes reach tgt_data in source order.
- R5: src_ready is high only during the load phase, when no byte is held and tgt_dclk is low. Exactly one handshake takes place per byte of the stream.
- R6: When the source offers no valid byte, tgt_dclk stays low with no partial pulse. Loading resumes once a byte is offered.
- R7: A rise of tgt_done before the last byte does not cut the stream short. Every byte up to and including the one flagged src_last is clocked out.
- R8: If tgt_done has not been high at any point by the end of the last byte, the host enters the error state and fail goes to 1.
- R9: With use_user_init=1, tgt_uclk toggles during the init phase with a high phase of ceil(SYS_MHZ/(2*UCLK_MAX_MHZ)) cycles. It gives at least INIT_CYC rising edges before ok, even when init-done rose earlier. With use_user_init=0, tgt_uclk stays 0.
- R10: ok rises only after a rising edge of tgt_init_done has been seen, and busy falls at the same time.
- R11: If the init phase lasts TMO system cycles without success, fail goes to 1.
- R12: fail stays high until rst_n, and start has no effect while it is high. A start after success clears ok and begins a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| start | input | 1 | Begin a configuration sequence |
| compress | input | 1 | 1: hold each byte for four configuration clocks |
| use_user_init | input | 1 | 1: drive the init clock during the init phase |
| src_data | input | 8 | Stream byte |
| src_valid | input | 1 | Source offers a byte |
| src_last | input | 1 | Offered byte is the final one |
| src_ready | output | 1 | Host takes the offered byte this cycle |
| tgt_cfg_n | output | 1 | Active-low configuration reset to target |
| tgt_status_n | input | 1 | Target ready (high) after reset |
| tgt_dclk | output | 1 | Configuration clock |
| tgt_data | output | 8 | Configuration data bus |
| tgt_done | input | 1 | Target has received the stream |
| tgt_init_done | input | 1 | Target entered user mode |
| tgt_uclk | output | 1 | User-supplied init clock |
| busy | output | 1 | Sequence in progress |
| ok | output | 1 | Configuration succeeded |
| fail | output | 1 | Sticky failure flag |

## Verification
The bench raises done one byte early and also on the last byte. A host that stopped at done would leave the received byte count short, and one that ignored a late done would fail a good load. In compressed mode it checks that only every fourth rising edge carries a fresh byte. A host that changed data between those edges, or that pulled extra handshakes, breaks the order of the received bytes. It also lets init-done rise after only a few user clocks, which catches a host that stops clocking before the minimum count. A withheld source and a target that never reaches user mode expose a clock that glitches during a stall, a missing error on an absent done, and a failure flag that does not stay set.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RSTP, ST_WRDY, ST_LOAD, ST_FIN, ST_INIT, ST_DONE, ST_ERR
  } cfgl_state_e;

  // half period (in system cycles) of the init clock so that it stays at or below max_mhz
  function automatic int unsigned uclk_half(input int unsigned sys_mhz, input int unsigned max_mhz);
    int unsigned h;
    h = (sys_mhz + 2 * max_mhz - 1) / (2 * max_mhz);
    return (h == 0) ? 1 : h;
  endfunction

  // configuration clock periods each byte is held for
  function automatic logic [2:0] beats_for(input logic comp);
    return comp ? 3'd4 : 3'd1;
  endfunction

endpackage

// File: rtl/cfgl_clkdiv.sv
module cfgl_clkdiv #(
  parameter int unsigned HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick,
  output logic ph
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
      ph  <= !ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: a stopped divider never starts a pulse
  a_r6_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ph) |=> !ph);

endmodule

// File: rtl/cfgl_feeder.sv
module cfgl_feeder
  import cfgl_pkg::*;
#(
  parameter int unsigned DCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       comp,
  input  logic [7:0] src_data,
  input  logic       src_valid,
  input  logic       src_last,
  output logic       src_ready,
  output logic       dclk,
  output logic [7:0] data,
  output logic       ev_accept,
  output logic       ev_stream_end
);
  logic       loaded;
  logic [2:0] beats;
  logic       last_q;
  logic       d_tick;
  logic       d_ph;
  logic       d_run;
  logic       ev_fall;

  assign d_run = loaded || d_ph;

  cfgl_clkdiv #(.HALF(DCLK_HALF)) u_dclk (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (d_run),
    .tick (d_tick),
    .ph   (d_ph)
  );

  assign dclk          = d_ph;
  assign src_ready     = en && !loaded;
  assign ev_accept     = src_ready && src_valid;
  assign ev_fall       = d_tick && d_ph && loaded;
  assign ev_stream_end = ev_fall && (beats == 3'd1) && last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      beats  <= '0;
      last_q <= 1'b0;
      data   <= '0;
    end else if (!en) begin
      loaded <= 1'b0;
    end else if (ev_accept) begin
      data   <= src_data;
      last_q <= src_last;
      beats  <= beats_for(comp);
      loaded <= 1'b1;
    end else if (ev_fall) begin
      beats <= beats - 1'b1;
      if (beats == 3'd1) loaded <= 1'b0;
    end
  end

  // R3: bus is stable whenever the clock is high
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> $stable(data));
  // R5: no handshake while a clock pulse is out
  a_r5_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> !src_ready);
  // R6: nothing held means no new pulse
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded && !dclk) |=> !dclk);

endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
  import cfgl_pkg::*;
#(
  parameter int unsigned RST_CYC  = 8,
  parameter int unsigned INIT_CYC = 4436,
  parameter int unsigned TMO      = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic compress,
  input  logic use_user_init,
  input  logic tgt_status_n,
  input  logic tgt_done,
  input  logic tgt_init_done,
  input  logic ev_stream_end,
  input  logic u_rise,
  input  logic u_ph,
  output logic load_en,
  output logic comp_q,
  output logic uclk_on,
  output logic cfg_n,
  output logic busy,
  output logic ok,
  output logic fail
);
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam int UCW = $clog2(INIT_CYC + 1);
  localparam int TCW = $clog2(TMO + 1);

  cfgl_state_e     state;
  logic [RCW-1:0]  rcnt;
  logic [UCW-1:0]  ucnt;
  logic [TCW-1:0]  tcnt;
  logic            user_q;
  logic            done_seen;
  logic            init_prev;
  logic            init_seen;
  logic            init_rise;
  logic            track_init;
  logic            go;
  logic            enough_clk;
  logic            success;

  assign init_rise  = tgt_init_done && !init_prev;
  assign track_init = state inside {ST_WRDY, ST_LOAD, ST_FIN, ST_INIT};
  assign go         = start && (state == ST_IDLE || state == ST_DONE);
  assign enough_clk = !user_q || ((ucnt == UCW'(INIT_CYC)) && !u_ph);
  assign success    = init_seen && enough_clk;

  assign load_en = (state == ST_LOAD);
  assign uclk_on = (state == ST_INIT) && user_q;
  assign cfg_n   = (state != ST_RSTP);
  assign busy    = !(state inside {ST_IDLE, ST_DONE, ST_ERR});
  assign ok      = (state == ST_DONE);
  assign fail    = (state == ST_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rcnt      <= '0;
      ucnt      <= '0;
      tcnt      <= '0;
      comp_q    <= 1'b0;
      user_q    <= 1'b0;
      done_seen <= 1'b0;
      init_prev <= 1'b0;
      init_seen <= 1'b0;
    end else begin
      init_prev <= tgt_init_done;
      if (track_init && init_rise) init_seen <= 1'b1;
      if (tgt_done && (state inside {ST_LOAD, ST_FIN})) done_seen <= 1'b1;
      if (go) begin
        state     <= ST_RSTP;
        rcnt      <= '0;
        comp_q    <= compress;
        user_q    <= use_user_init;
        done_seen <= 1'b0;
        init_seen <= 1'b0;
      end else begin
        case (state)
          ST_RSTP: begin
            if (rcnt == RCW'(RST_CYC - 1)) state <= ST_WRDY;
            else rcnt <= rcnt + 1'b1;
          end
          ST_WRDY: if (tgt_status_n) state <= ST_LOAD;
          ST_LOAD: if (ev_stream_end) state <= ST_FIN;
          ST_FIN: begin
            tcnt  <= '0;
            ucnt  <= '0;
            state <= (done_seen || tgt_done) ? ST_INIT : ST_ERR;
          end
          ST_INIT: begin
            tcnt <= tcnt + 1'b1;
            if (u_rise && ucnt != UCW'(INIT_CYC)) ucnt <= ucnt + 1'b1;
            if (success) state <= ST_DONE;
            else if (tcnt == TCW'(TMO - 1)) state <= ST_ERR;
          end
          default: ;
        endcase
      end
    end
  end

  a_r12_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);
  a_r2_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRDY && !tgt_status_n && !start) |=> (state == ST_WRDY));
  a_r8_no_done_err: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN && !done_seen && !tgt_done) |=> fail);
  a_r9_min_uclk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ok) && user_q) |-> (ucnt == UCW'(INIT_CYC)));
  a_r10_ok_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> init_seen);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgl_pkg::*;
#(
  parameter int unsigned DCLK_HALF    = 2,
  parameter int unsigned SYS_MHZ      = 200,
  parameter int unsigned UCLK_MAX_MHZ = 100,
  parameter int unsigned RST_CYC      = 8,
  parameter int unsigned INIT_CYC     = 4436,
  parameter int unsigned TMO          = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       compress,
  input  logic       use_user_init,
  input  logic [7:0] src_data,
  input  logic       src_valid,
  input  logic       src_last,
  output logic       src_ready,
  output logic       tgt_cfg_n,
  input  logic       tgt_status_n,
  output logic       tgt_dclk,
  output logic [7:0] tgt_data,
  input  logic       tgt_done,
  input  logic       tgt_init_done,
  output logic       tgt_uclk,
  output logic       busy,
  output logic       ok,
  output logic       fail
);
  localparam int unsigned UHALF = uclk_half(SYS_MHZ, UCLK_MAX_MHZ);

  logic load_en;
  logic comp_q;
  logic uclk_on;
  logic ev_accept;
  logic ev_stream_end;
  logic u_tick;
  logic u_ph;
  logic u_rise;
  logic u_run;

  assign u_run    = uclk_on || u_ph;
  assign u_rise   = u_tick && !u_ph;
  assign tgt_uclk = u_ph;

  cfgl_ctrl #(.RST_CYC(RST_CYC), .INIT_CYC(INIT_CYC), .TMO(TMO)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .compress     (compress),
    .use_user_init(use_user_init),
    .tgt_status_n (tgt_status_n),
    .tgt_done     (tgt_done),
    .tgt_init_done(tgt_init_done),
    .ev_stream_end(ev_stream_end),
    .u_rise       (u_rise),
    .u_ph         (u_ph),
    .load_en      (load_en),
    .comp_q       (comp_q),
    .uclk_on      (uclk_on),
    .cfg_n        (tgt_cfg_n),
    .busy         (busy),
    .ok           (ok),
    .fail         (fail)
  );

  cfgl_feeder #(.DCLK_HALF(DCLK_HALF)) u_feed (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (load_en),
    .comp         (comp_q),
    .src_data     (src_data),
    .src_valid    (src_valid),
    .src_last     (src_last),
    .src_ready    (src_ready),
    .dclk         (tgt_dclk),
    .data         (tgt_data),
    .ev_accept    (ev_accept),
    .ev_stream_end(ev_stream_end)
  );

  cfgl_clkdiv #(.HALF(UHALF)) u_uclk (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (u_run),
    .tick (u_tick),
    .ph   (u_ph)
  );

  // R5: handshakes only happen while loading with the clock low
  a_r5_accept_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> (load_en && !tgt_dclk));
  // R9: init clock silent unless selected
  a_r9_uclk_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!uclk_on && !u_ph) |=> !tgt_uclk);

endmodule

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
  localparam int CLK_PER = 10;
  localparam int HALF    = 2;
  localparam int RSTC    = 4;
  localparam int INITC   = 20;
  localparam int TMOC    = 400;

  typedef struct packed {
    logic       comp;
    logic       user;
    logic [7:0] nb;
    logic [7:0] dat;   // done after this many bytes, 255 = never
    logic [7:0] initn; // init-done delay, 255 = never
    logic [3:0] gap;
    logic       eok;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{1'b0, 1'b0, 8'd8, 8'd7,   8'd10,  4'd0, 1'b1},
    '{1'b1, 1'b1, 8'd6, 8'd5,   8'd30,  4'd3, 1'b1},
    '{1'b0, 1'b0, 8'd5, 8'd255, 8'd10,  4'd2, 1'b0},
    '{1'b1, 1'b1, 8'd4, 8'd4,   8'd5,   4'd0, 1'b1},
    '{1'b0, 1'b0, 8'd6, 8'd5,   8'd255, 4'd0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, compress = 1'b0, use_user_init = 1'b0;
  logic [7:0] src_data = '0;
  logic src_valid = 1'b0, src_last = 1'b0;
  logic tgt_status_n = 1'b0, tgt_done = 1'b0, tgt_init_done = 1'b0;
  logic src_ready, tgt_cfg_n, tgt_dclk, tgt_uclk, busy, ok, fail;
  logic [7:0] tgt_data;

  always #(CLK_PER/2) clk = ~clk;

  cfg_loader #(.DCLK_HALF(HALF), .SYS_MHZ(100), .UCLK_MAX_MHZ(100), .RST_CYC(RSTC),
               .INIT_CYC(INITC), .TMO(TMOC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .compress(compress),
    .use_user_init(use_user_init), .src_data(src_data), .src_valid(src_valid),
    .src_last(src_last), .src_ready(src_ready), .tgt_cfg_n(tgt_cfg_n),
    .tgt_status_n(tgt_status_n), .tgt_dclk(tgt_dclk), .tgt_data(tgt_data),
    .tgt_done(tgt_done), .tgt_init_done(tgt_init_done), .tgt_uclk(tgt_uclk),
    .busy(busy), .ok(ok), .fail(fail));

  int total = 0, bad = 0;
  bit m_on = 0, m_comp = 0, m_user = 0, hold_src = 0, hs_q = 0, dprev = 0, uprev = 0;
  int m_n, m_dat, m_init, m_gap;
  int rises, rx, mism, tx, hs_cnt, urises, badw, hi_len, uhi, rst_len, wviol, rviol, icnt;
  int stat_cnt = 0, cyc = 0;

  function automatic logic [7:0] pat(input int i);
    return 8'((32'hA5 ^ (i * 37)) & 32'hFF);
  endfunction

  task automatic check(input bit cond, input string req, input string what, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) hs_q <= src_valid && src_ready;

  // target and source model, all at the falling system clock edge
  always @(negedge clk) begin
    cyc++;
    if (!tgt_cfg_n) begin
      stat_cnt = 0;
      tgt_status_n = 1'b0;
    end else if (stat_cnt < 6) stat_cnt++;
    else tgt_status_n = 1'b1;
    if (m_on) begin
      if (!tgt_cfg_n) rst_len++;
      if (!tgt_status_n && tgt_cfg_n && (src_ready || tgt_dclk)) wviol++;
      if (src_ready && tgt_dclk) rviol++;
      if (hs_q) begin tx++; hs_cnt++; end
      src_valid = !hold_src && (tx < m_n) && !(m_gap != 0 && (cyc % m_gap) == 0);
      src_data  = pat(tx);
      src_last  = (tx == m_n - 1);
      if (tgt_dclk) begin
        hi_len++;
        if (!dprev) begin
          if (!m_comp || (rises % 4) == 0) begin
            if (tgt_data !== pat(rx)) mism++;
            rx++;
            if (rx == m_dat) tgt_done = 1'b1;
          end
          rises++;
        end
      end else if (dprev) begin
        if (hi_len != HALF) badw++;
        hi_len = 0;
      end
      dprev = tgt_dclk;
      if (tgt_uclk) begin
        uhi++;
        if (!uprev) urises++;
      end else if (uprev) begin
        if (uhi != 1) badw++;
        uhi = 0;
      end
      uprev = tgt_uclk;
      if (tgt_done && m_init != 255) begin
        if (m_user) begin
          if (urises >= m_init) tgt_init_done = 1'b1;
        end else begin
          icnt++;
          if (icnt >= m_init) tgt_init_done = 1'b1;
        end
      end
    end
  end

  task automatic setup_vec(input vec_t v, input bit hold);
    @(negedge clk); #1;
    m_on = 0; rst_n = 1'b0; hold_src = hold;
    src_valid = 1'b0; tgt_done = 1'b0; tgt_init_done = 1'b0;
    rises = 0; rx = 0; mism = 0; tx = 0; hs_cnt = 0; urises = 0; badw = 0;
    hi_len = 0; uhi = 0; rst_len = 0; wviol = 0; rviol = 0; icnt = 0;
    dprev = 0; uprev = 0;
    m_comp = v.comp; m_user = v.user; m_n = int'(v.nb); m_dat = int'(v.dat);
    m_init = int'(v.initn); m_gap = int'(v.gap);
    compress = v.comp; use_user_init = v.user;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1; m_on = 1;
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 4000 && !(ok || fail); k++) @(negedge clk);
    #2;
  endtask

  task automatic check_vec(input vec_t v);
    check(ok == v.eok, "R10/R8/R11", "ok", int'(ok), int'(v.eok));
    check(fail == !v.eok, "R8/R11/R12", "fail", int'(fail), int'(!v.eok));
    check(rx == m_n, "R7", "bytes received", rx, m_n);
    check(mism == 0, "R4", "byte mismatches", mism, 0);
    check(hs_cnt == m_n, "R5", "handshakes", hs_cnt, m_n);
    check(rises == (v.comp ? 4 : 1) * m_n, "R4", "dclk rises", rises, (v.comp ? 4 : 1) * m_n);
    check(badw == 0, "R3", "bad high widths", badw, 0);
    check(rviol == 0, "R5", "ready while dclk high", rviol, 0);
    check(rst_len == RSTC, "R2", "reset pulse length", rst_len, RSTC);
    check(wviol == 0, "R2", "activity before ready", wviol, 0);
    if (!v.user) check(urises == 0, "R9", "uclk rises unused", urises, 0);
    else if (v.eok) check(urises >= INITC, "R9", "uclk rises", urises, INITC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check(busy == 0 && ok == 0 && fail == 0, "R1", "status after reset", int'({busy, ok, fail}), 0);
    check(tgt_cfg_n == 1 && tgt_dclk == 0 && tgt_uclk == 0 && src_ready == 0, "R1",
          "pins after reset", int'({tgt_cfg_n, tgt_dclk, tgt_uclk, src_ready}), 8);

    for (int i = 0; i < 5; i++) begin
      setup_vec(VEC[i], 1'b0);
      wait_end();
      check_vec(VEC[i]);
    end

    // R6: withheld source stalls the clock low
    setup_vec('{1'b0, 1'b0, 8'd3, 8'd2, 8'd5, 4'd0, 1'b1}, 1'b1);
    repeat (60) @(negedge clk);
    #1;
    check(rises == 0 && tgt_dclk == 0, "R6", "pulses during stall", rises, 0);
    check(busy == 1, "R6", "busy during stall", int'(busy), 1);
    hold_src = 0;
    wait_end();
    check(ok == 1 && rx == 3 && mism == 0, "R6", "load after stall", rx, 3);

    // R12: start after success clears ok
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    @(negedge clk); #1;
    check(ok == 0 && busy == 1, "R12", "restart after ok", int'({ok, busy}), 1);

    // R12: fail is sticky and start is ignored
    setup_vec(VEC[2], 1'b0);
    wait_end();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    check(fail == 1 && busy == 0 && tgt_cfg_n == 1, "R12", "fail held",
          int'({fail, busy, tgt_cfg_n}), 5);
    rst_n = 1'b0; m_on = 0;
    @(negedge clk); #1;
    check(fail == 0, "R12", "fail cleared by reset", int'(fail), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule